// File: doc/BRIEF.md
# Synchronized Dual-Channel DAC Serial Update Master

This block sits on the host side of a two-channel serial DAC and turns simple requests into 16-bit serial frames. It drives a three-wire bus: clock, active-low select and data. The clock idles high. Data changes while the clock is high, so each bit is steady at the falling clock edge, where the converter samples it. Each request arrives on a valid/ready handshake and does one of three things: it writes channel A, it writes channel B, or it updates both channels so that their outputs start to move together.

A simultaneous update is sent as two frames. The first frame parks the B code in the converter's holding latch without changing either output. The second frame writes the A code, and that same write moves the held B code into channel B. The master remembers the speed mode used by the previous write. It places that mode into the first frame of a simultaneous update, so the converter's supply current does not jump and the outputs do not glitch. The power-down bit of each request goes into every frame of that request. A parameter sets the serial clock half-period in system clock cycles.

Top module: `dac_pair_master`

## Requirements
- R1: After reset, dac_cs_n = 1, dac_sclk = 1, req_ready = 1 and done = 0.
- R2: Each frame has exactly 16 falling clock edges while select is low, most significant bit first. dac_sdo changes only while dac_sclk is high and holds its value through every low phase.
- R3: req_op = 0 (write A) sends one frame: bit 15 = 1, bit 14 = speed, bit 13 = power-down, bit 12 = 0, bits 11..0 = req_code_a.
- R4: req_op = 1 (write B) sends one frame: bit 15 = 0, bit 14 = speed, bit 13 = power-down, bit 12 = 0, bits 11..0 = req_code_b.
- R5: req_op = 2 or 3 (update both) sends two frames. The first is 0, previous speed, power-down, 1, req_code_b. The second is 1, req_fast, power-down, 0, req_code_a. No channel output changes after the first frame; both change after the second.
- R6: The stored speed mode is 0 (slow) after reset. It becomes req_fast of each completed request, and the first frame of an update-both request carries the stored value, not the new one.
- R7: Bit 13 of every frame of a request equals the req_pdown value captured when that request was accepted.
- R8: While select is low, every clock high phase and every low phase lasts at least DIV_HALF system cycles. This includes the high time from select falling to the first falling edge, and the high time after the 16th falling edge before select rises.
- R9: Select stays high for at least 2*DIV_HALF system cycles (one serial clock period) between consecutive frames, including the two frames of an update-both request.
- R10: req_ready is high only while the master is idle. A request is taken when req_valid and req_ready are both high. req_valid while busy is ignored and starts no frame.
- R11: done is a one-cycle pulse, raised together with req_ready after select rises at the end of the last frame of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request taken this cycle if valid |
| req_op | input | 2 | 0 write A, 1 write B, 2 or 3 update both |
| req_code_a | input | 12 | Code for channel A |
| req_code_b | input | 12 | Code for channel B |
| req_fast | input | 1 | Speed mode for this request (1 fast) |
| req_pdown | input | 1 | Power-down bit for this request's frames |
| done | output | 1 | One-cycle pulse at request completion |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_cs_n | output | 1 | Active-low frame select |
| dac_sdo | output | 1 | Serial data, MSB first |

## Verification
Two things can fall in the same cycle. The first is a new request arriving while the previous frame is still finishing its select gap; the second is done rising together with req_ready. The bench provokes the first by raising req_valid with different data while a frame is in flight. It then judges at the bus that no extra frame and no changed word appeared. For the second it checks that req_ready is high in the cycle done pulses and that done is gone one cycle later. A model of the converter's latches, driven only by the captured frames, shows that no channel changes between the two frames of an update-both request.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int FRAME_W = 16;
  localparam int CODE_W  = 12;

  // request opcodes; bit 1 set means update both channels
  localparam logic [1:0] OP_WR_A = 2'd0;
  localparam logic [1:0] OP_WR_B = 2'd1;

  function automatic logic [FRAME_W-1:0] pack_word(
    input logic              to_a,
    input logic              spd,
    input logic              pd,
    input logic              hold_only,
    input logic [CODE_W-1:0] code
  );
    return {to_a, spd, pd, hold_only, code};
  endfunction
endpackage

// File: rtl/dpm_timer.sv
module dpm_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expire
);
  localparam int W = (HALF < 2) ? 1 : $clog2(HALF);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)           cnt_d = W'(HALF - 1);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/dpm_serializer.sv
module dpm_serializer
  import dpm_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] word,
  output logic               idle,
  output logic               fin,
  output logic               sclk,
  output logic               cs_n,
  output logic               sdo
);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  typedef enum logic [2:0] {
    SR_IDLE, SR_LEAD, SR_LOW, SR_HIGH, SR_TAIL, SR_GAP1, SR_GAP2
  } sr_state_e;

  sr_state_e          st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [BW-1:0]      bit_q, bit_d;
  logic               sclk_q, sclk_d;
  logic               cs_q, cs_d;
  logic               fin_q, fin_d;
  logic               restart, expire;

  dpm_timer #(.HALF(HALF)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .expire  (expire)
  );

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    sclk_d  = sclk_q;
    cs_d    = cs_q;
    fin_d   = 1'b0;
    restart = 1'b0;
    unique case (st_q)
      SR_IDLE: if (start) begin
        sh_d    = word;
        bit_d   = '0;
        cs_d    = 1'b0;
        restart = 1'b1;
        st_d    = SR_LEAD;
      end
      SR_LEAD, SR_HIGH: if (expire) begin
        sclk_d  = 1'b0;
        restart = 1'b1;
        st_d    = SR_LOW;
      end
      SR_LOW: if (expire) begin
        sclk_d  = 1'b1;
        restart = 1'b1;
        if (bit_q == LAST_BIT) begin
          st_d = SR_TAIL;
        end else begin
          bit_d = bit_q + 1'b1;
          sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
          st_d  = SR_HIGH;
        end
      end
      SR_TAIL: if (expire) begin
        cs_d    = 1'b1;
        restart = 1'b1;
        st_d    = SR_GAP1;
      end
      SR_GAP1: if (expire) begin
        restart = 1'b1;
        st_d    = SR_GAP2;
      end
      SR_GAP2: if (expire) begin
        fin_d = 1'b1;
        sh_d  = '0;
        st_d  = SR_IDLE;
      end
      default: st_d = SR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SR_IDLE;
      sh_q   <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b1;
      cs_q   <= 1'b1;
      fin_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      fin_q  <= fin_d;
    end
  end

  assign idle = (st_q == SR_IDLE);
  assign fin  = fin_q;
  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign sdo  = sh_q[FRAME_W-1];
endmodule

// File: rtl/dpm_sequencer.sv
module dpm_sequencer
  import dpm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [CODE_W-1:0]  req_code_a,
  input  logic [CODE_W-1:0]  req_code_b,
  input  logic               req_fast,
  input  logic               req_pdown,
  input  logic               eng_fin,
  output logic               eng_start,
  output logic [FRAME_W-1:0] eng_word,
  output logic               done
);
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_GO1, SQ_WAIT1, SQ_GO2, SQ_WAIT2
  } sq_state_e;

  sq_state_e         st_q, st_d;
  logic [1:0]        op_q;
  logic [CODE_W-1:0] a_q, b_q;
  logic              fast_q, pd_q;
  logic              spd_q, spd_d;
  logic              done_q, done_d;
  logic              cap_en;
  logic              both;

  assign both = op_q[1];

  always_comb begin
    st_d      = st_q;
    spd_d     = spd_q;
    done_d    = 1'b0;
    cap_en    = 1'b0;
    eng_start = 1'b0;
    eng_word  = '0;
    req_ready = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          cap_en = 1'b1;
          st_d   = SQ_GO1;
        end
      end
      SQ_GO1: begin
        eng_start = 1'b1;
        if (both) begin
          // park B in the holding latch, keep the previous speed mode
          eng_word = pack_word(1'b0, spd_q, pd_q, 1'b1, b_q);
        end else begin
          spd_d = fast_q;
          if (op_q[0] == OP_WR_B[0])
            eng_word = pack_word(1'b0, fast_q, pd_q, 1'b0, b_q);
          else
            eng_word = pack_word(1'b1, fast_q, pd_q, 1'b0, a_q);
        end
        st_d = SQ_WAIT1;
      end
      SQ_WAIT1: if (eng_fin) begin
        if (both) begin
          st_d = SQ_GO2;
        end else begin
          done_d = 1'b1;
          st_d   = SQ_IDLE;
        end
      end
      SQ_GO2: begin
        eng_start = 1'b1;
        eng_word  = pack_word(1'b1, fast_q, pd_q, 1'b0, a_q);
        spd_d     = fast_q;
        st_d      = SQ_WAIT2;
      end
      SQ_WAIT2: if (eng_fin) begin
        done_d = 1'b1;
        st_d   = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      spd_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      spd_q  <= spd_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_WR_A;
      a_q    <= '0;
      b_q    <= '0;
      fast_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (cap_en) begin
      op_q   <= req_op;
      a_q    <= req_code_a;
      b_q    <= req_code_b;
      fast_q <= req_fast;
      pd_q   <= req_pdown;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/dac_pair_master.sv
module dac_pair_master
  import dpm_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [11:0] req_code_a,
  input  logic [11:0] req_code_b,
  input  logic        req_fast,
  input  logic        req_pdown,
  output logic        done,
  output logic        dac_sclk,
  output logic        dac_cs_n,
  output logic        dac_sdo
);
  logic               rst_meta, rst_n_s;
  logic               eng_start, eng_fin, eng_idle;
  logic [FRAME_W-1:0] eng_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  dpm_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_code_a (req_code_a),
    .req_code_b (req_code_b),
    .req_fast   (req_fast),
    .req_pdown  (req_pdown),
    .eng_fin    (eng_fin),
    .eng_start  (eng_start),
    .eng_word   (eng_word),
    .done       (done)
  );

  dpm_serializer #(.HALF(DIV_HALF)) u_ser (
    .clk   (clk),
    .rst_n (rst_n_s),
    .start (eng_start && eng_idle),
    .word  (eng_word),
    .idle  (eng_idle),
    .fin   (eng_fin),
    .sclk  (dac_sclk),
    .cs_n  (dac_cs_n),
    .sdo   (dac_sdo)
  );
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic sclk,
  input logic cs_n,
  input logic sdo
);
  logic       sclk_p, cs_p;
  logic [4:0] fall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p   <= 1'b1;
      cs_p     <= 1'b1;
      fall_cnt <= '0;
    end else begin
      sclk_p <= sclk;
      cs_p   <= cs_n;
      if (cs_p && !cs_n)        fall_cnt <= '0;
      else if (sclk_p && !sclk) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  // R1: idle bus keeps the clock high
  assert_idle_clock_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  // R2: data steady through a low phase
  assert_data_steady_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && !sclk_p) |-> $stable(sdo));
  // R2: sixteen falling edges per frame, clock high at select release
  assert_sixteen_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_p && cs_n) |-> (fall_cnt == 5'd16 && sclk));
  // R8: select falls only with the clock high
  assert_select_falls_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_p && !cs_n) |-> sclk);
  // R8: clock falls only inside a frame
  assert_edge_inside_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_p && !sclk) |-> !cs_n);
  // R10: no ready while a frame is on the bus
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);
  // R10: accepting drops ready
  assert_accept_drops_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R11: done coincides with ready and lasts one cycle
  assert_done_with_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dac_pair_master dpm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .sclk      (dac_sclk),
  .cs_n      (dac_cs_n),
  .sdo       (dac_sdo)
);

// File: tb/dac_pair_master_bench.sv
module dac_pair_master_bench;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [11:0] req_code_a = '0;
  logic [11:0] req_code_b = '0;
  logic        req_fast = 1'b0;
  logic        req_pdown = 1'b0;
  logic        done, dac_sclk, dac_cs_n, dac_sdo;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dac_pair_master #(.DIV_HALF(HALF)) u_dac_pair_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_code_a(req_code_a), .req_code_b(req_code_b),
    .req_fast(req_fast), .req_pdown(req_pdown), .done(done),
    .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n), .dac_sdo(dac_sdo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor with converter latch model
  logic [15:0] frm [0:511];
  logic [11:0] la_snap [0:511];
  logic [11:0] lb_snap [0:511];
  int          nfr = 0;
  logic [15:0] sr = '0;
  int          nbits = 0;
  logic        p_sclk = 1'b1, p_cs = 1'b1;
  logic [11:0] m_la = '0, m_lb = '0, m_db = '0;
  int hi_run = 0, lo_run = 0, gap_run = 0;
  int min_hi = 1000, min_lo = 1000, min_gap = 1000;
  bit seen_frame = 0;
  bit bad_bits = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_cs_n) gap_run++;
      if (!dac_cs_n && dac_sclk) hi_run++;
      if (!dac_cs_n && !dac_sclk) lo_run++;
      if (p_cs && !dac_cs_n) begin
        if (seen_frame && gap_run < min_gap) min_gap = gap_run;
        nbits = 0;
      end
      if (p_sclk && !dac_sclk && !dac_cs_n) begin
        sr = {sr[14:0], dac_sdo};
        nbits++;
        if (hi_run < min_hi) min_hi = hi_run;
        hi_run = 0;
      end
      if (!p_sclk && dac_sclk) begin
        if (lo_run < min_lo) min_lo = lo_run;
        lo_run = 0;
      end
      if (!p_cs && dac_cs_n) begin
        if (hi_run < min_hi) min_hi = hi_run;
        hi_run = 0;
        if (nbits != 16) bad_bits = 1;
        if (sr[15]) begin
          m_la = sr[11:0];
          m_lb = m_db;
        end else if (!sr[12]) begin
          m_lb = sr[11:0];
          m_db = sr[11:0];
        end else begin
          m_db = sr[11:0];
        end
        frm[nfr] = sr;
        la_snap[nfr] = m_la;
        lb_snap[nfr] = m_lb;
        nfr++;
        seen_frame = 1;
        gap_run = 0;
      end
      p_sclk = dac_sclk;
      p_cs = dac_cs_n;
    end
  end

  logic m_spd = 1'b0;

  task automatic do_req(input logic [1:0] op, input logic [11:0] a, input logic [11:0] b,
                        input logic fast, input logic pd, input bit poke);
    int base, nexp;
    logic [15:0] e0, e1;
    logic [11:0] la0, lb0;
    base = nfr; la0 = m_la; lb0 = m_lb;
    e1 = '0;
    if (op == 2'd0) begin
      e0 = {1'b1, fast, pd, 1'b0, a}; nexp = 1;
    end else if (op == 2'd1) begin
      e0 = {1'b0, fast, pd, 1'b0, b}; nexp = 1;
    end else begin
      e0 = {1'b0, m_spd, pd, 1'b1, b};
      e1 = {1'b1, fast, pd, 1'b0, a}; nexp = 2;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_code_a = a; req_code_b = b;
    req_fast = fast; req_pdown = pd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 ready low after accept", req_ready, 0);
    if (poke) begin
      repeat (7) @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_code_a = ~a; req_fast = ~fast; req_pdown = ~pd;
      chk(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready with done", req_ready, 1);
    chk(nfr - base == nexp, "R10 frame count", nfr - base, nexp);
    if (op[1]) begin
      chk(frm[base] == e0, "R5 first frame hold-only B (R6 speed)", frm[base], e0);
      chk(frm[base+1] == e1, "R5 second frame A", frm[base+1], e1);
      chk(la_snap[base] == la0 && lb_snap[base] == lb0, "R5 no output change after first",
          {la_snap[base], lb_snap[base]}, {la0, lb0});
      chk(m_la == a && m_lb == b, "R5 both latches updated", {m_la, m_lb}, {a, b});
    end else if (op == 2'd0) begin
      chk(frm[base] == e0, "R3 write A word", frm[base], e0);
      chk(m_la == a && m_lb == lb0, "R3 A latch only", {m_la, m_lb}, {a, lb0});
    end else begin
      chk(frm[base] == e0, "R4 write B word", frm[base], e0);
      chk(m_lb == b && m_la == la0, "R4 B latch only", {m_la, m_lb}, {la0, b});
    end
    chk(frm[base][13] == pd, "R7 power-down bit", frm[base][13], pd);
    @(negedge clk);
    chk(done == 1'b0, "R11 done single cycle", done, 0);
    m_spd = fast;
  endtask

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dac_cs_n == 1'b1, "R1 select idle", dac_cs_n, 1);
    chk(dac_sclk == 1'b1, "R1 clock idle high", dac_sclk, 1);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(done == 1'b0, "R1 done low", done, 0);
    // R6: first update-both after reset carries slow mode in frame one
    do_req(2'd2, 12'h800, 12'hFFF, 1'b1, 1'b0, 1'b0);
    do_req(2'd0, 12'hFFF, 12'h000, 1'b1, 1'b0, 1'b1);
    do_req(2'd1, 12'h000, 12'h000, 1'b0, 1'b1, 1'b0);
    do_req(2'd3, 12'h001, 12'hABC, 1'b0, 1'b1, 1'b1);
    do_req(2'd2, 12'h5A5, 12'h3C3, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) begin
      do_req(2'($urandom_range(0, 3)), 12'($urandom), 12'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
    end
    repeat (10) @(negedge clk);
    chk(!bad_bits, "R2 sixteen bits per frame", bad_bits, 0);
    chk(min_hi >= HALF, "R8 min clock high phase", min_hi, HALF);
    chk(min_lo >= HALF, "R8 min clock low phase", min_lo, HALF);
    chk(min_gap >= 2 * HALF, "R9 min select gap", min_gap, 2 * HALF);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule